// File: doc/BRIEF.md
# Primality radius search engine

This block finds, for an unsigned integer N, the smallest non-negative distance r such that N-r and N+r are both prime. It is used as the arithmetic core of a lookup appliance. The host first writes a table of consecutive primes into on-chip storage through a simple write port. It then presents N with a start pulse and waits for a one-cycle done pulse. The radius, a flag that marks N itself as prime, and a flag that reports a failed search are then valid on the outputs.

The search steps r upward from zero. Each candidate value first goes through a cheap screen. This screen rejects even values and computes a shift-and-subtract greatest common divisor against the product of the small odd primes. Only values that survive the screen go on to full trial division. The trial division divides by table primes in ascending order, using one bit-serial divider, until the square of the divisor exceeds the value. The lower value N-r is always tested first, and the upper value N+r is tested only when the lower one is prime. At r = 0 both values are N, so N is tested only once.

Top module: `prad_engine`

## Requirements
- R1: While reset is held and after it is released, busy, done, the radius, the prime flag and the overflow flag are all 0.
- R2: A write with the table write enable high stores the table data at the given address. Entries are used from address 0 upward, up to the highest address written. The table must hold consecutive primes starting at 2, enough to cover the square root of N plus the radius limit.
- R3: When a search ends with a pair found, the radius output equals the smallest r at which both N-r and N+r are prime.
- R4: The prime flag is 1 after a search exactly when the result is r = 0 with no overflow, that is, when N is prime.
- R5: If no pair is found for any r up to the radius limit (999 by default), the overflow flag is 1 and the radius and prime flag read 0.
- R6: A lower value N-r below 2 counts as not prime and ends the search with the overflow flag set. So N = 0 or 1 reports overflow.
- R7: Busy rises in the cycle after an accepted start and stays high until the result is ready. Done is high for exactly one cycle, and busy is low in that cycle.
- R8: A start pulse while busy is high is ignored, and the running search completes for the original N.
- R9: The result outputs change only in the cycle where done is high, and they hold from one done pulse to the next.
- R10: N+r is formed one bit wider than N, so values of N near the top of the input range give correct radii.
- R11: N is captured on the accepted start cycle. Later changes on the N input do not affect the running search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tblWe | input | 1 | Prime table write enable |
| tblAddr | input | AW | Prime table write address |
| tblData | input | PW | Prime value to store |
| start | input | 1 | Start a search (accepted when not busy) |
| nIn | input | NW | Value N to search around |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse, result valid |
| rOut | output | RW | Smallest primality radius |
| primeOut | output | 1 | N is prime (radius 0) |
| ovfOut | output | 1 | No radius found within the limit |

## Verification
A wrong table index or a wrong divider remainder shows up as a wrong radius at the next done pulse. It is usually too small, because one composite value is let through. A screen that flags shared factors wrongly makes a prime look composite, so the radius comes out too large or the overflow flag sets. These errors are seen only at the end of the search, which takes a few hundred to a few thousand cycles. Errors in the controller show up sooner: busy and done are compared on every clock, so a stuck state or a lost pulse shows within one cycle of the faulty step.

// File: rtl/prad_pkg.sv
package prad_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SCREEN, S_GCD, S_FETCH, S_CHECK, S_DIV, S_DONE
  } prad_state_e;

  // control strobes toward the datapath
  typedef struct packed {
    logic loadN;
    logic rInc;
    logic selB;
    logic gcdInit;
    logic gcdStep;
    logic tdFirst;
    logic idxInc;
    logic divInit;
    logic divStep;
    logic finFound;
    logic finOvf;
  } prad_strb_t;

  // datapath conditions toward the control
  typedef struct packed {
    logic vLow;
    logic vSmall;
    logic vEven;
    logic gcdDone;
    logic gcdShared;
    logic tdPrime;
    logic divDone;
    logic remZero;
    logic sideB;
    logic rIsZero;
    logic rAtLim;
  } prad_stat_t;

  function automatic bit smallIsPrime(input int unsigned c);
    if (c < 2) return 1'b0;
    for (int unsigned d = 2; d * d <= c; d++)
      if (c % d == 0) return 1'b0;
    return 1'b1;
  endfunction

  // k-th prime, counting 2 as index 0
  function automatic int unsigned kthPrime(input int unsigned k);
    int unsigned cnt;
    cnt = 0;
    for (int unsigned c = 2; c < 1000; c++) begin
      if (smallIsPrime(c)) begin
        if (cnt == k) return c;
        cnt++;
      end
    end
    return 0;
  endfunction

  // product of the odd primes with index 1 .. k-1
  function automatic int unsigned oddPrimorial(input int unsigned k);
    int unsigned prod;
    prod = 1;
    for (int unsigned i = 1; i < k; i++) prod = prod * kthPrime(i);
    return prod;
  endfunction

endpackage

// File: rtl/prad_ctrl.sv
module prad_ctrl
  import prad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  prad_stat_t stat,
  output prad_strb_t strb,
  output logic       busy,
  output logic       done
);

  prad_state_e state, nxt;
  logic isComp, isPrime;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strb    = '0;
    nxt     = state;
    isComp  = 1'b0;
    isPrime = 1'b0;
    case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          strb.loadN = 1'b1;
          nxt        = S_SCREEN;
        end else begin
          nxt = S_IDLE;
        end
      end
      S_SCREEN: begin
        if (stat.vLow) begin
          strb.finOvf = 1'b1;
          nxt         = S_DONE;
        end else if (stat.vSmall) begin
          strb.tdFirst = 1'b1;
          nxt          = S_FETCH;
        end else if (stat.vEven) begin
          isComp = 1'b1;
        end else begin
          strb.gcdInit = 1'b1;
          nxt          = S_GCD;
        end
      end
      S_GCD: begin
        if (stat.gcdDone) begin
          if (stat.gcdShared) isComp = 1'b1;
          else begin
            strb.tdFirst = 1'b1;
            nxt          = S_FETCH;
          end
        end else begin
          strb.gcdStep = 1'b1;
        end
      end
      S_FETCH: nxt = S_CHECK;
      S_CHECK: begin
        if (stat.tdPrime) isPrime = 1'b1;
        else begin
          strb.divInit = 1'b1;
          nxt          = S_DIV;
        end
      end
      S_DIV: begin
        if (stat.divDone) begin
          if (stat.remZero) isComp = 1'b1;
          else begin
            strb.idxInc = 1'b1;
            nxt         = S_FETCH;
          end
        end else begin
          strb.divStep = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase

    if (isComp) begin
      if (stat.rAtLim) begin
        strb.finOvf = 1'b1;
        nxt         = S_DONE;
      end else begin
        strb.rInc = 1'b1;
        nxt       = S_SCREEN;
      end
    end
    if (isPrime) begin
      if (!stat.sideB && !stat.rIsZero) begin
        strb.selB = 1'b1;
        nxt       = S_SCREEN;
      end else begin
        strb.finFound = 1'b1;
        nxt           = S_DONE;
      end
    end
  end

  assign done = (state == S_DONE);
  assign busy = (state != S_IDLE) && (state != S_DONE);

  // R7: done lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: busy is low while done is shown
  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R7: an accepted start raises busy next cycle
  p_start_takes_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
  // R7: busy only drops into a done cycle
  p_busy_ends_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

// File: rtl/prad_dpath.sv
module prad_dpath
  import prad_pkg::*;
#(
  parameter int NW        = 32,
  parameter int RW        = 10,
  parameter int RLIM      = 999,
  parameter int PW        = 16,
  parameter int TBL_DEPTH = 6542,
  parameter int SCREEN_K  = 9,
  localparam int AW       = $clog2(TBL_DEPTH)
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tblWe,
  input  logic [AW-1:0] tblAddr,
  input  logic [PW-1:0] tblData,
  input  logic [NW-1:0] nIn,
  input  prad_strb_t    strb,
  output prad_stat_t    stat,
  output logic [RW-1:0] rOut,
  output logic          primeOut,
  output logic          ovfOut
);

  localparam int VW   = NW + 1;
  localparam int GW   = (VW > 32) ? VW : 32;
  localparam int CW   = AW + 1;
  localparam int MW   = (2 * PW > VW) ? 2 * PW : VW;
  localparam int DCW  = $clog2(VW + 1);
  localparam int unsigned SMAX = kthPrime(SCREEN_K - 1);
  localparam logic [GW-1:0] PRIM = GW'(oddPrimorial(SCREEN_K));

  logic [NW-1:0]  nReg;
  logic [RW-1:0]  rCur;
  logic           sideB;
  logic [VW-1:0]  v;
  logic [VW-1:0]  nExt, rExt;
  logic [GW-1:0]  gx, gy;
  logic [PW-1:0]  tbl [TBL_DEPTH];
  logic [CW-1:0]  tblCnt, idx;
  logic [PW-1:0]  pRd;
  logic [2*PW-1:0] pSq;
  logic [PW:0]    rem, trial;
  logic [VW-1:0]  q;
  logic [DCW-1:0] dcnt;

  assign nExt = VW'(nReg);
  assign rExt = VW'(rCur);

  // candidate value and search position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nReg  <= '0;
      rCur  <= '0;
      sideB <= 1'b0;
      v     <= '0;
    end else if (strb.loadN) begin
      nReg  <= nIn;
      rCur  <= '0;
      sideB <= 1'b0;
      v     <= VW'(nIn);
    end else if (strb.rInc) begin
      rCur  <= rCur + RW'(1);
      sideB <= 1'b0;
      v     <= nExt - rExt - VW'(1);
    end else if (strb.selB) begin
      sideB <= 1'b1;
      v     <= nExt + rExt;
    end
  end

  // screen: binary gcd of odd candidate against odd primorial
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gx <= '0;
      gy <= '0;
    end else if (strb.gcdInit) begin
      gx <= GW'(v);
      gy <= PRIM;
    end else if (strb.gcdStep) begin
      if (!gx[0])       gx <= gx >> 1;
      else if (!gy[0])  gy <= gy >> 1;
      else if (gx > gy) gx <= gx - gy;
      else              gy <= gy - gx;
    end
  end

  // prime table storage
  always_ff @(posedge clk) begin
    if (tblWe) tbl[tblAddr] <= tblData;
    pRd <= tbl[idx[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tblCnt <= '0;
    else if (tblWe && (CW'(tblAddr) + CW'(1) > tblCnt))
      tblCnt <= CW'(tblAddr) + CW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            idx <= '0;
    else if (strb.tdFirst) idx <= '0;
    else if (strb.idxInc)  idx <= idx + CW'(1);
  end

  // bit-serial remainder of v by the current table prime
  assign trial = {rem[PW-1:0], q[VW-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem  <= '0;
      q    <= '0;
      dcnt <= '0;
    end else if (strb.divInit) begin
      rem  <= '0;
      q    <= v;
      dcnt <= DCW'(VW);
    end else if (strb.divStep) begin
      rem  <= (trial >= {1'b0, pRd}) ? trial - {1'b0, pRd} : trial;
      q    <= q << 1;
      dcnt <= dcnt - DCW'(1);
    end
  end

  assign pSq = {{PW{1'b0}}, pRd} * {{PW{1'b0}}, pRd};

  // results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rOut     <= '0;
      primeOut <= 1'b0;
      ovfOut   <= 1'b0;
    end else if (strb.finFound) begin
      rOut     <= rCur;
      primeOut <= (rCur == '0);
      ovfOut   <= 1'b0;
    end else if (strb.finOvf) begin
      rOut     <= '0;
      primeOut <= 1'b0;
      ovfOut   <= 1'b1;
    end
  end

  always_comb begin
    stat.vLow      = (v < VW'(2));
    stat.vSmall    = (v <= VW'(SMAX));
    stat.vEven     = !v[0];
    stat.gcdDone   = (gx == gy);
    stat.gcdShared = (gx != GW'(1));
    stat.tdPrime   = (idx >= tblCnt) || (MW'(pSq) > MW'(v));
    stat.divDone   = (dcnt == '0);
    stat.remZero   = (rem == '0);
    stat.sideB     = sideB;
    stat.rIsZero   = (rCur == '0);
    stat.rAtLim    = (rCur == RW'(RLIM));
  end

  // R4: prime flag only with a zero radius and no overflow
  p_prime_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    primeOut |-> (rOut == '0 && !ovfOut));
  // R5: overflow reports a cleared radius
  p_ovf_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    ovfOut |-> (rOut == '0 && !primeOut));
  // R3: reported radius never exceeds the limit
  p_r_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    rOut <= RW'(RLIM));
  // R4: upper side is tested only for a nonzero radius
  p_upper_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    sideB |-> (rCur != '0));

endmodule

// File: rtl/prad_engine.sv
module prad_engine
  import prad_pkg::*;
#(
  parameter int NW        = 32,
  parameter int RW        = 10,
  parameter int RLIM      = 999,
  parameter int PW        = 16,
  parameter int TBL_DEPTH = 6542,
  parameter int SCREEN_K  = 9,
  localparam int AW       = $clog2(TBL_DEPTH)
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tblWe,
  input  logic [AW-1:0] tblAddr,
  input  logic [PW-1:0] tblData,
  input  logic          start,
  input  logic [NW-1:0] nIn,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] rOut,
  output logic          primeOut,
  output logic          ovfOut
);

  prad_strb_t strb;
  prad_stat_t stat;

  prad_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  prad_dpath #(
    .NW        (NW),
    .RW        (RW),
    .RLIM      (RLIM),
    .PW        (PW),
    .TBL_DEPTH (TBL_DEPTH),
    .SCREEN_K  (SCREEN_K)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .tblWe    (tblWe),
    .tblAddr  (tblAddr),
    .tblData  (tblData),
    .nIn      (nIn),
    .strb     (strb),
    .stat     (stat),
    .rOut     (rOut),
    .primeOut (primeOut),
    .ovfOut   (ovfOut)
  );

  // R9: the radius changes only while done is shown
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rOut) |-> done);

endmodule

// File: tb/prad_engine_bench.sv
module prad_engine_bench;
  localparam int NW = 16, RW = 10, RLIM = 12, PW = 16, DEPTH = 64, AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tblWe = 1'b0;
  logic [AW-1:0] tblAddr = '0;
  logic [PW-1:0] tblData = '0;
  logic          start = 1'b0;
  logic [NW-1:0] nIn = '0;
  logic          busy, done, primeOut, ovfOut;
  logic [RW-1:0] rOut;

  int  vecs = 0, errs = 0, cycles = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  prad_engine #(.NW(NW), .RW(RW), .RLIM(RLIM), .PW(PW), .TBL_DEPTH(DEPTH), .SCREEN_K(9))
  u_prad_engine (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData),
    .start(start), .nIn(nIn), .busy(busy), .done(done), .rOut(rOut),
    .primeOut(primeOut), .ovfOut(ovfOut)
  );

  function automatic bit refPrime(input longint val);
    if (val < 2) return 1'b0;
    for (longint d = 2; d * d <= val; d++)
      if (val % d == 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic refRadius(input longint n, output int r, output bit ovf);
    r = 0;
    ovf = 1'b1;
    for (int k = 0; k <= RLIM; k++) begin
      if (n - k < 2) return;
      if (refPrime(n - k) && refPrime(n + k)) begin
        r = k;
        ovf = 1'b0;
        return;
      end
    end
  endtask

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  // one search, compared every clock against the behavioural model
  task automatic search(input longint n, input bit poke, input string tag);
    int er, cyc;
    bit eo;
    logic [RW-1:0] heldR;
    refRadius(n, er, eo);
    @(negedge clk);
    nIn   = NW'(n);
    start = 1'b1;
    heldR = rOut;
    @(negedge clk);
    start = 1'b0;
    nIn   = ~nIn;  // R11: input moves after capture
    cyc   = 0;
    while (done !== 1'b1 && cyc < 60000) begin
      check(busy === 1'b1, "R7 busy during search", busy, 1);
      check(rOut === heldR, "R9 radius held during search", rOut, heldR);
      if (poke && cyc == 5) begin
        start = 1'b1;           // R8: start while busy
        nIn   = NW'(n + 7);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (cyc >= 60000) begin
      check(1'b0, {tag, " search watchdog"}, cyc, 0);
      return;
    end
    check(busy === 1'b0, "R7 busy low with done", busy, 0);
    check(ovfOut === eo, {tag, " R5 R6 overflow flag"}, ovfOut, eo);
    check(rOut === (eo ? RW'(0) : RW'(er)), {tag, " R3 radius"}, rOut, eo ? 0 : er);
    check(primeOut === (!eo && er == 0), {tag, " R4 prime flag"}, primeOut, (!eo && er == 0));
    heldR = rOut;
    @(negedge clk);
    check(done === 1'b0, "R7 done single cycle", done, 0);
    check(rOut === heldR, "R9 radius held after done", rOut, heldR);
  endtask

  // global watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
  end

  initial begin
    int addr;
    longint ovfN;
    int er;
    bit eo;

    repeat (3) @(negedge clk);
    // R1: reset values
    check({busy, done, primeOut, ovfOut} === 4'b0, "R1 flags in reset", {busy, done, primeOut, ovfOut}, 0);
    check(rOut === '0, "R1 radius in reset", rOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, primeOut, ovfOut} === 4'b0, "R1 flags after reset", {busy, done, primeOut, ovfOut}, 0);

    // R2: load consecutive primes from address 0
    addr = 0;
    for (int c = 2; c <= 300; c++) begin
      if (refPrime(c)) begin
        tblWe   = 1'b1;
        tblAddr = AW'(addr);
        tblData = PW'(c);
        @(negedge clk);
        addr++;
      end
    end
    tblWe = 1'b0;

    search(2, 1'b0, "R4 N=2");
    search(3, 1'b0, "R4 N=3");
    search(4, 1'b0, "R3 N=4");
    search(1, 1'b0, "R6 N=1");
    search(0, 1'b0, "R6 N=0");
    search(841, 1'b0, "R2 N=841");
    search(899, 1'b0, "R2 N=899");
    search(65521, 1'b0, "R4 large prime");
    search(65535, 1'b0, "R10 max value");
    search(1000, 1'b1, "R8 start while busy");

    ovfN = 0;
    for (longint n = 1000; n < 65000; n++) begin
      refRadius(n, er, eo);
      if (eo) begin
        ovfN = n;
        break;
      end
    end
    if (ovfN != 0) search(ovfN, 1'b0, "R5 no radius within limit");

    for (int i = 0; i < 10; i++) search($urandom_range(65535, 2), 1'b0, "R3 random");
    search(65533, 1'b1, "R11 R8 near max");

    finish_run();
  end

endmodule